// File: doc/BRIEF.md
# Segment Selector Translation Unit

This unit converts a segmented memory reference into a flat 32-bit linear address. A request carries a 16-bit selector and a 32-bit offset. The selector names a descriptor, which is found in a small, fully associative cache. A separate load port fills that cache with 64-bit descriptors, each paired with the selector it belongs to.

From the cached descriptor the unit takes the segment base, the 20-bit limit and the flag bits. It scales the limit by the granularity flag and checks the offset against that scaled limit. If the offset is inside the segment, the unit returns the base plus the offset. Otherwise it reports a fault, together with a cause code.

Results are registered and appear one cycle after the request. Descriptor-table fetches, paging and privilege checks other than the present flag are left to the surrounding logic.

Top module: `seg_xlate_unit`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rsp_valid` is 0. Reset empties the cache, so a request with any non-null selector made before the first load faults with cause MISS.
- R2: Selector bits 15:3 are the table index and bit 2 picks the table (0 global, 1 local). Lookup matches on bits 15:2 only, so the privilege bits 1:0 have no effect on the result. The same index in the two tables names two different descriptors.
- R3: A request whose selector has bits 15:2 all zero faults with cause NULL (code 1), even when a descriptor was loaded under that selector.
- R4: A request whose selector is not in the cache faults with cause MISS (code 2).
- R5: A hit whose descriptor has the present flag (bit 47) at 0 faults with cause ABSENT (code 3).
- R6: Descriptor fields sit at these bits:
  - limit = {bits 51:48, bits 15:0}
  - base = {bits 63:56, bits 39:16}
  - granularity flag G = bit 55, size flag D = bit 54, available flag AV = bit 52
  - on a successful translation, `rsp_big` shows D and `rsp_avail` shows AV.
- R7: The effective limit is the raw limit when G=0, and the limit shifted left by 12 with FFFh filled into the low bits when G=1. An offset greater than the effective limit faults with cause LIMIT (code 4). An offset equal to it translates.
- R8: A successful translation gives cause OK (code 0) and `rsp_linear` = base + offset modulo 2^32. The result appears in the cycle after the request.
- R9: On every fault, `rsp_fault` is 1 and `rsp_linear`, `rsp_big` and `rsp_avail` are 0.
- R10: A load whose selector bits 15:2 match a cached entry overwrites that entry. Otherwise the load goes to the slot named by a round-robin pointer, which starts at slot 0 and advances only on such loads. A load takes effect from the next cycle, so a request in the same cycle sees the old contents.
- R11: With base 10000000h and limit 001FFh, the highest valid offset translates to 100001FFh when G=0 and to 101FFFFFh when G=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_valid | input | 1 | Write the descriptor on `ld_desc` into the cache |
| ld_sel | input | 16 | Selector that the loaded descriptor belongs to |
| ld_desc | input | 64 | Descriptor being loaded |
| req_valid | input | 1 | Translation request |
| req_sel | input | 16 | Selector of the request |
| req_offset | input | 32 | Offset of the request |
| rsp_valid | output | 1 | Result valid, one cycle after `req_valid` |
| rsp_fault | output | 1 | Request faulted |
| rsp_cause | output | 3 | 0 OK, 1 NULL, 2 MISS, 3 ABSENT, 4 LIMIT |
| rsp_linear | output | 32 | Linear address, zero on a fault |
| rsp_big | output | 1 | Size flag D of the segment |
| rsp_avail | output | 1 | Available flag AV of the segment |

## Verification
The tag-uniqueness assertion in the cache assumes that loads arrive only through the port. Because a load with a matching tag overwrites rather than duplicates, at most one entry can hit. The bench therefore reloads selectors that differ only in their privilege bits, and it loads more selectors than there are slots, so both the overwrite path and the eviction path are exercised.

The response assertions assume that `req_valid` is never unknown once reset is released. The bench drives every input to a defined value on every cycle, including the cycles in which it holds `rst_n` low.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [2:0] {
    XC_OK     = 3'd0,
    XC_NULL   = 3'd1,
    XC_MISS   = 3'd2,
    XC_ABSENT = 3'd3,
    XC_LIMIT  = 3'd4
  } xlate_cause_e;

  typedef struct packed {
    logic [31:0] base;
    logic [19:0] limit;
    logic        gran;
    logic        big;
    logic        avail;
    logic        present;
  } seg_attr_t;

  function automatic seg_attr_t unpack_desc(input logic [63:0] d);
    seg_attr_t a;
    a.base    = {d[63:56], d[39:16]};
    a.limit   = {d[51:48], d[15:0]};
    a.gran    = d[55];
    a.big     = d[54];
    a.avail   = d[52];
    a.present = d[47];
    return a;
  endfunction

endpackage

// File: rtl/seg_desc_cache.sv
module seg_desc_cache #(
  parameter int ENTRIES = 4,
  parameter int TAG_W   = 14,
  parameter int DESC_W  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DESC_W-1:0] wr_desc,
  input  logic [TAG_W-1:0]  rd_tag,
  output logic              rd_hit,
  output logic [DESC_W-1:0] rd_desc
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0] vld_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DESC_W-1:0]  desc_q [ENTRIES];
  logic [PTR_W-1:0]   ptr_q, ptr_d;
  logic               ptr_en;

  logic [ENTRIES-1:0] rd_match;
  logic [ENTRIES-1:0] wr_match;
  logic [ENTRIES-1:0] wr_sel;
  logic               wr_any_match;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign rd_match[i] = vld_q[i] && (tag_q[i] == rd_tag);
    assign wr_match[i] = vld_q[i] && (tag_q[i] == wr_tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[i] <= 1'b0;
      end else if (wr_en && wr_sel[i]) begin
        vld_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_sel[i]) begin
        tag_q[i]  <= wr_tag;
        desc_q[i] <= wr_desc;
      end
    end
  end

  always_comb begin
    wr_any_match = |wr_match;
    wr_sel       = '0;
    if (wr_any_match) begin
      wr_sel = wr_match;
    end else begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (ptr_q == PTR_W'(i)) wr_sel[i] = 1'b1;
      end
    end
  end

  always_comb begin
    ptr_en = wr_en && !wr_any_match;
    if (ptr_q == PTR_W'(ENTRIES - 1)) ptr_d = '0;
    else                              ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_comb begin
    rd_hit  = |rd_match;
    rd_desc = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rd_match[i]) rd_desc = rd_desc | desc_q[i];
    end
  end

  // R10: overwrite-on-match keeps tags unique, so at most one entry hits
  a_r10_unique_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_match));

endmodule

// File: rtl/seg_limit_check.sv
module seg_limit_check
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 20
) (
  input  seg_attr_t         attr,
  input  logic [ADDR_W-1:0] offset,
  output logic              over_limit,
  output logic [ADDR_W-1:0] linear
);

  localparam int PAGE_W = ADDR_W - LIM_W;

  logic [ADDR_W-1:0] eff_limit;

  always_comb begin
    if (attr.gran) eff_limit = {attr.limit, {PAGE_W{1'b1}}};
    else           eff_limit = {{PAGE_W{1'b0}}, attr.limit};
    over_limit = offset > eff_limit;
    linear     = attr.base + offset;
  end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
  import seg_xlate_pkg::*;
#(
  parameter int CACHE_ENTRIES = 4,
  parameter int SEL_W         = 16,
  parameter int ADDR_W        = 32,
  parameter int DESC_W        = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_valid,
  input  logic [SEL_W-1:0]  ld_sel,
  input  logic [DESC_W-1:0] ld_desc,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic [ADDR_W-1:0] req_offset,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_linear,
  output logic              rsp_big,
  output logic              rsp_avail
);

  localparam int RPL_W = 2;
  localparam int TAG_W = SEL_W - RPL_W;

  logic [TAG_W-1:0]  req_tag;
  logic              hit;
  logic [DESC_W-1:0] hit_desc;
  seg_attr_t         attr;
  logic              over_limit;
  logic [ADDR_W-1:0] sum;

  xlate_cause_e      cause_d;
  logic [ADDR_W-1:0] linear_d;
  logic              big_d, avail_d;

  logic              valid_q;
  xlate_cause_e      cause_q;
  logic [ADDR_W-1:0] linear_q;
  logic              big_q, avail_q;

  assign req_tag = req_sel[SEL_W-1:RPL_W];

  seg_desc_cache #(
    .ENTRIES (CACHE_ENTRIES),
    .TAG_W   (TAG_W),
    .DESC_W  (DESC_W)
  ) i_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ld_valid),
    .wr_tag  (ld_sel[SEL_W-1:RPL_W]),
    .wr_desc (ld_desc),
    .rd_tag  (req_tag),
    .rd_hit  (hit),
    .rd_desc (hit_desc)
  );

  assign attr = unpack_desc(hit_desc);

  seg_limit_check #(
    .ADDR_W (ADDR_W)
  ) i_limit (
    .attr       (attr),
    .offset     (req_offset),
    .over_limit (over_limit),
    .linear     (sum)
  );

  // next-state: fault priority NULL > MISS > ABSENT > LIMIT
  always_comb begin
    if (req_tag == '0)      cause_d = XC_NULL;
    else if (!hit)          cause_d = XC_MISS;
    else if (!attr.present) cause_d = XC_ABSENT;
    else if (over_limit)    cause_d = XC_LIMIT;
    else                    cause_d = XC_OK;
    if (cause_d == XC_OK) begin
      linear_d = sum;
      big_d    = attr.big;
      avail_d  = attr.avail;
    end else begin
      linear_d = '0;
      big_d    = 1'b0;
      avail_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      cause_q  <= XC_OK;
      linear_q <= '0;
      big_q    <= 1'b0;
      avail_q  <= 1'b0;
    end else begin
      valid_q <= req_valid;
      if (req_valid) begin
        cause_q  <= cause_d;
        linear_q <= linear_d;
        big_q    <= big_d;
        avail_q  <= avail_d;
      end
    end
  end

  assign rsp_valid  = valid_q;
  assign rsp_cause  = cause_q;
  assign rsp_fault  = valid_q && (cause_q != XC_OK);
  assign rsp_linear = linear_q;
  assign rsp_big    = big_q;
  assign rsp_avail  = avail_q;

  // R8: a result only follows a request one cycle earlier
  a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));

  // R3: a null selector always yields the NULL cause
  a_r3_null_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_sel[SEL_W-1:RPL_W] == '0) |=> (rsp_cause == XC_NULL));

  // R9: a faulted result carries no address or flags
  a_r9_fault_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_linear == '0 && !rsp_big && !rsp_avail));

  // R4: a request to an empty cache cannot produce a translation
  a_r4_miss_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !hit) |=> rsp_fault);

endmodule

// File: tb/test_seg_xlate_unit.sv
module test_seg_xlate_unit;

  localparam int N = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_valid;
  logic [15:0] ld_sel;
  logic [63:0] ld_desc;
  logic        req_valid;
  logic [15:0] req_sel;
  logic [31:0] req_offset;
  logic        rsp_valid, rsp_fault, rsp_big, rsp_avail;
  logic [2:0]  rsp_cause;
  logic [31:0] rsp_linear;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  string cur_tag = "R1";
  string exp_tag = "R1";

  always #5 clk = ~clk;

  seg_xlate_unit i_seg_xlate_unit (
    .clk(clk), .rst_n(rst_n),
    .ld_valid(ld_valid), .ld_sel(ld_sel), .ld_desc(ld_desc),
    .req_valid(req_valid), .req_sel(req_sel), .req_offset(req_offset),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_linear(rsp_linear), .rsp_big(rsp_big), .rsp_avail(rsp_avail)
  );

  // behavioural reference model
  bit          m_vld [N];
  logic [13:0] m_tag [N];
  logic [63:0] m_desc[N];
  int          m_ptr;
  bit          e_valid;
  int          e_cause;
  logic [31:0] e_lin;
  bit          e_big, e_av;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) m_vld[i] = 0;
      m_ptr = 0;
      e_valid = 0;
    end else begin
      e_valid = req_valid;
      if (req_valid) begin
        int idx;
        idx = -1;
        exp_tag = cur_tag;
        for (int i = 0; i < N; i++)
          if (m_vld[i] && m_tag[i] == req_sel[15:2]) idx = i;
        e_lin = 0; e_big = 0; e_av = 0;
        if (req_sel[15:2] == 0) e_cause = 1;
        else if (idx < 0) e_cause = 2;
        else begin
          logic [63:0] d;
          longint lim, eff, base;
          d    = m_desc[idx];
          lim  = longint'({d[51:48], d[15:0]});
          base = longint'({d[63:56], d[39:16]});
          eff  = d[55] ? lim * 4096 + 4095 : lim;
          if (!d[47]) e_cause = 3;
          else if (longint'(req_offset) > eff) e_cause = 4;
          else begin
            e_cause = 0;
            e_lin   = 32'(base + longint'(req_offset));
            e_big   = d[54];
            e_av    = d[52];
          end
        end
      end
      if (ld_valid) begin
        int hitw;
        hitw = -1;
        for (int i = 0; i < N; i++)
          if (m_vld[i] && m_tag[i] == ld_sel[15:2]) hitw = i;
        if (hitw < 0) begin
          hitw = m_ptr;
          m_ptr = (m_ptr + 1) % N;
        end
        m_vld[hitw] = 1; m_tag[hitw] = ld_sel[15:2]; m_desc[hitw] = ld_desc;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (rsp_valid !== e_valid) begin
        fails++;
        $display("FAIL %s valid: actual %0b expected %0b", exp_tag, rsp_valid, e_valid);
      end else if (e_valid) begin
        if (rsp_cause !== 3'(e_cause) || rsp_fault !== (e_cause != 0) ||
            rsp_linear !== e_lin || rsp_big !== e_big || rsp_avail !== e_av) begin
          fails++;
          $display("FAIL %s (R9 zeros on fault): actual cause=%0d fault=%0b lin=%h d=%0b av=%0b expected cause=%0d lin=%h d=%0b av=%0b",
                   exp_tag, rsp_cause, rsp_fault, rsp_linear, rsp_big, rsp_avail,
                   e_cause, e_lin, e_big, e_av);
        end
      end
    end
  end

  function automatic logic [63:0] mk(input logic [31:0] base, input logic [19:0] lim,
                                     input bit g, input bit d, input bit av, input bit p);
    return {base[31:24], g, d, 1'b0, av, lim[19:16], p, 7'b0010010, base[23:0], lim[15:0]};
  endfunction

  task automatic step(input bit lv, input logic [15:0] ls, input logic [63:0] ldd,
                      input bit rv, input logic [15:0] rs, input logic [31:0] off,
                      input string tag);
    @(negedge clk);
    ld_valid = lv; ld_sel = ls; ld_desc = ldd;
    req_valid = rv; req_sel = rs; req_offset = off; cur_tag = tag;
  endtask

  task automatic load(input logic [15:0] s, input logic [63:0] d, input string tag);
    step(1, s, d, 0, 0, 0, tag);
  endtask

  task automatic req(input logic [15:0] s, input logic [31:0] off, input string tag);
    step(0, 0, 0, 1, s, off, tag);
  endtask

  initial begin
    rst_n = 0; ld_valid = 0; ld_sel = 0; ld_desc = 0;
    req_valid = 0; req_sel = 0; req_offset = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    #1;
    checks++;  // R1: no output right after reset
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset valid: actual %0b expected 0", rsp_valid);
    end
    req(16'h0008, 0, "R1");
    req(16'h0000, 0, "R3");
    req(16'h0003, 0, "R3");
    // R10: same-cycle load is not yet visible
    step(1, 16'h0008, mk(32'h1000_0000, 20'h001FF, 0, 1, 1, 1), 1, 16'h0008, 0, "R10");
    req(16'h0008, 32'h1FF, "R11");
    req(16'h0008, 32'h200, "R7");
    load(16'h0010, mk(32'h1000_0000, 20'h001FF, 1, 0, 1, 1), "R10");
    req(16'h0010, 32'h001F_FFFF, "R11");
    req(16'h0010, 32'h0020_0000, "R7");
    req(16'h000B, 32'h1FF, "R2");
    req(16'h000C, 0, "R2");
    load(16'h0018, mk(32'h0000_4000, 20'hFFFFF, 0, 1, 1, 0), "R5");
    req(16'h0018, 0, "R5");
    load(16'h0020, mk(32'hFFFF_F000, 20'hFFFFF, 1, 1, 0, 1), "R8");
    req(16'h0020, 32'h0000_2000, "R8");
    req(16'h0020, 32'hFFFF_FFFF, "R7");
    load(16'h0000, mk(32'h0, 20'hFFFFF, 0, 0, 0, 1), "R3");
    req(16'h0000, 0, "R3");
    load(16'h0028, mk(32'h1234_5678, 20'hA5A5A, 0, 0, 0, 1), "R6");
    req(16'h0028, 32'h100, "R6");
    req(16'h0008, 0, "R10");
    req(16'h0010, 0, "R10");
    load(16'h0012, mk(32'h0ABC_0000, 20'h00010, 0, 1, 0, 1), "R10");
    req(16'h0010, 32'h10, "R10");
    req(16'h0010, 32'h11, "R7");
    req(16'h0018, 0, "R10");
    req(16'h0020, 32'h5, "R10");
    load(16'h000C, mk(32'h0055_0000, 20'h0000F, 0, 1, 1, 1), "R2");
    req(16'h000C, 32'hF, "R2");
    req(16'h0008, 32'hF, "R2");
    begin
      logic [31:0] lfsr;
      lfsr = 32'h1ACE_B00C;
      for (int k = 0; k < 200; k++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        if (lfsr[3:0] == 4'd0)
          load({9'd0, lfsr[6:4], lfsr[8:7], 2'b0},
               mk(lfsr ^ 32'h5A5A_0000, {lfsr[31:20]} << lfsr[9], lfsr[10], lfsr[11], lfsr[12], lfsr[13] | lfsr[14]),
               "R10");
        else
          req({9'd0, lfsr[6:4], lfsr[8:7], lfsr[16:15]},
              lfsr[17] ? {20'd0, lfsr[31:20]} : {lfsr[27:18], 22'h3FF000 | 22'(lfsr[12:0])},
              "R7");
      end
    end
    step(0, 0, 0, 0, 0, 0, "R8");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule